// File: doc/BRIEF.md
# Serial Port DMA Request and Completion Status Logic

This block sits between the FIFOs of a serial port and a DMA engine. For each of the two directions it watches a FIFO level and raises two request lines. The single request means at least one word can move. The burst request means a block of words can move. On the transmit side the level is the number of free slots in the FIFO. On the receive side it is the number of words waiting. Each direction has its own DMA enable, and that enable gates both of its request lines.

The block also keeps three sticky raw status bits: transmit DMA done, receive DMA done, and end of transmission. Each status bit has a clear input. The transmit-done bit refuses to clear while transmit DMA is still enabled, so software must drop the enable before it clears. A masked OR of the three bits drives a single interrupt line. The request path can be built with no register or with a one-cycle register stage, chosen by a parameter.

Top module: `sp_dma_req`

## Requirements
- R1: With rx_dma_en=1, rx_sreq is 1 exactly when rx_fill >= 1 (combinational in the default build, REQ_REG=0).
- R2: With rx_dma_en=1, rx_breq is 1 exactly when rx_fill >= 4.
- R3: With tx_dma_en=1, tx_sreq is 1 exactly when tx_free >= 1.
- R4: With tx_dma_en=1, tx_breq is 1 exactly when tx_free >= 4.
- R5: When a channel's enable is 0, both of its request lines are 0 whatever its level.
- R6: A one-cycle tx_dma_done pulse sets raw_status[0] at the next clock edge, and the bit then stays set.
- R7: clr_tx_done has no effect while tx_dma_en=1. With tx_dma_en=0, clr_tx_done clears raw_status[0] at the next edge.
- R8: An rx_dma_done pulse sets raw_status[1]. clr_rx_done clears it at the next edge whatever the value of rx_dma_en.
- R9: raw_status[2] is set at the edge after a cycle with tx_free equal to FIFO_DEPTH (8) and shifter_idle=1. clr_eot clears it only in a cycle where that condition is false.
- R10: When a set event and an accepted clear arrive in the same cycle, the status bit ends up set.
- R11: irq is 1 exactly when some bit of raw_status & irq_mask is 1, with mask bit i matching status bit i.
- R12: After reset, raw_status is 000 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_dma_en | input | 1 | Transmit DMA enable |
| rx_dma_en | input | 1 | Receive DMA enable |
| tx_free | input | LVL_W (4) | Free slots in the transmit FIFO |
| rx_fill | input | LVL_W (4) | Words held in the receive FIFO |
| tx_dma_done | input | 1 | Pulse: transmit DMA transfer finished |
| rx_dma_done | input | 1 | Pulse: receive DMA transfer finished |
| shifter_idle | input | 1 | Serializer has shifted out its last bit |
| clr_tx_done | input | 1 | Clear request for raw_status[0] |
| clr_rx_done | input | 1 | Clear request for raw_status[1] |
| clr_eot | input | 1 | Clear request for raw_status[2] |
| irq_mask | input | 3 | Interrupt mask, one bit per status bit |
| tx_sreq | output | 1 | Transmit single request |
| tx_breq | output | 1 | Transmit burst request |
| rx_sreq | output | 1 | Receive single request |
| rx_breq | output | 1 | Receive burst request |
| raw_status | output | 3 | {eot, rx_done, tx_done} |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest case to reach is a transmit-done clear that arrives while the transmit enable is still high. The bit must survive that clear and then fall once the enable drops. To reach it, the stimulus sets the bit, holds the enable, issues the clear, checks the bit, and then clears again with the enable low. The same-cycle race between a set and a clear needs both pulses on one edge, so a dedicated task drives them together. The end-of-transmission bit is cleared once while its set condition still holds and once after that condition has gone away.

// File: rtl/sp_dma_pkg.sv
package sp_dma_pkg;
   localparam int unsigned NUM_CH    = 2;
   localparam int unsigned CH_TX     = 0;
   localparam int unsigned CH_RX     = 1;
   localparam int unsigned NUM_ST    = 3;
   localparam int unsigned ST_TXDONE = 0;
   localparam int unsigned ST_RXDONE = 1;
   localparam int unsigned ST_EOT    = 2;
endpackage

// File: rtl/sp_dma_chan_req.sv
module sp_dma_chan_req #(
   parameter int unsigned LVL_W      = 4,
   parameter int unsigned SINGLE_LVL = 1,
   parameter int unsigned BURST_LVL  = 4,
   parameter bit          REQ_REG    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [LVL_W-1:0] level,
   output logic             sreq,
   output logic             breq
);
   localparam logic [LVL_W-1:0] S_THR = LVL_W'(SINGLE_LVL);
   localparam logic [LVL_W-1:0] B_THR = LVL_W'(BURST_LVL);

   logic s_hit;
   logic b_hit;

   assign s_hit = en && (level >= S_THR);
   assign b_hit = en && (level >= B_THR);

   generate
      if (REQ_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sreq <= 1'b0;
               breq <= 1'b0;
            end else begin
               sreq <= s_hit;
               breq <= b_hit;
            end
         end
         // R5: a disabled channel drops its requests one cycle later
         p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> (!sreq && !breq));
      end else begin : g_comb
         assign sreq = s_hit;
         assign breq = b_hit;
         // R5: a disabled channel never requests
         p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !en |-> (!sreq && !breq));
      end
   endgenerate

   // R2/R4: a burst request always comes with a single request
   p_burst_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      breq |-> sreq);
endmodule

// File: rtl/sp_dma_stat_bit.sv
module sp_dma_stat_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic clr_ok_i,
   output logic q_o
);
   logic clr_take;

   assign clr_take = clr_i && clr_ok_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= set_i | (q_o & ~clr_take);
   end

   // R10: a set event wins over any clear
   p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   // R7: a refused or absent clear leaves the bit set
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o && !(clr_i && clr_ok_i)) |=> q_o);
   // R8: an accepted clear with no set empties the bit
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && clr_ok_i && !set_i) |=> !q_o);
endmodule

// File: rtl/sp_dma_irq.sv
module sp_dma_irq #(
   parameter int unsigned N = 3
) (
   input  logic [N-1:0] status,
   input  logic [N-1:0] mask,
   output logic         irq
);
   assign irq = |(status & mask);
endmodule

// File: rtl/sp_dma_req.sv
module sp_dma_req
   import sp_dma_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 8,
   parameter int unsigned SINGLE_LVL = 1,
   parameter int unsigned BURST_LVL  = 4,
   parameter bit          REQ_REG    = 1'b0,
   localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_dma_en,
   input  logic             rx_dma_en,
   input  logic [LVL_W-1:0] tx_free,
   input  logic [LVL_W-1:0] rx_fill,
   input  logic             tx_dma_done,
   input  logic             rx_dma_done,
   input  logic             shifter_idle,
   input  logic             clr_tx_done,
   input  logic             clr_rx_done,
   input  logic             clr_eot,
   input  logic [2:0]       irq_mask,
   output logic             tx_sreq,
   output logic             tx_breq,
   output logic             rx_sreq,
   output logic             rx_breq,
   output logic [2:0]       raw_status,
   output logic             irq
);
   localparam logic [LVL_W-1:0] EMPTY_FREE = LVL_W'(FIFO_DEPTH);

   initial begin : p_param_chk
      assert (SINGLE_LVL >= 1 && BURST_LVL >= SINGLE_LVL && BURST_LVL <= FIFO_DEPTH)
         else $error("sp_dma_req: request thresholds out of range");
   end

   // channel request generation
   logic [NUM_CH-1:0] ch_en;
   logic [LVL_W-1:0]  ch_lvl [NUM_CH];
   logic [NUM_CH-1:0] ch_sreq;
   logic [NUM_CH-1:0] ch_breq;

   always_comb begin
      ch_en[CH_TX]  = tx_dma_en;
      ch_en[CH_RX]  = rx_dma_en;
      ch_lvl[CH_TX] = tx_free;
      ch_lvl[CH_RX] = rx_fill;
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         sp_dma_chan_req #(
            .LVL_W      (LVL_W),
            .SINGLE_LVL (SINGLE_LVL),
            .BURST_LVL  (BURST_LVL),
            .REQ_REG    (REQ_REG)
         ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (ch_en[c]),
            .level (ch_lvl[c]),
            .sreq  (ch_sreq[c]),
            .breq  (ch_breq[c])
         );
      end
   endgenerate

   assign tx_sreq = ch_sreq[CH_TX];
   assign tx_breq = ch_breq[CH_TX];
   assign rx_sreq = ch_sreq[CH_RX];
   assign rx_breq = ch_breq[CH_RX];

   // sticky status bits
   logic              drained;
   logic [NUM_ST-1:0] st_set;
   logic [NUM_ST-1:0] st_clr;
   logic [NUM_ST-1:0] st_ok;
   logic [NUM_ST-1:0] st_q;

   assign drained = (tx_free == EMPTY_FREE) && shifter_idle;

   always_comb begin
      st_set[ST_TXDONE] = tx_dma_done;
      st_clr[ST_TXDONE] = clr_tx_done;
      st_ok[ST_TXDONE]  = ~tx_dma_en;
      st_set[ST_RXDONE] = rx_dma_done;
      st_clr[ST_RXDONE] = clr_rx_done;
      st_ok[ST_RXDONE]  = 1'b1;
      st_set[ST_EOT]    = drained;
      st_clr[ST_EOT]    = clr_eot;
      st_ok[ST_EOT]     = 1'b1;
   end

   generate
      for (genvar s = 0; s < NUM_ST; s++) begin : g_st
         sp_dma_stat_bit u_bit (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (st_set[s]),
            .clr_i    (st_clr[s]),
            .clr_ok_i (st_ok[s]),
            .q_o      (st_q[s])
         );
      end
   endgenerate

   assign raw_status = st_q;

   sp_dma_irq #(.N(NUM_ST)) u_irq (
      .status (st_q),
      .mask   (irq_mask),
      .irq    (irq)
   );

   // R7: transmit-done survives a clear while transmit DMA is enabled
   p_txdone_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_status[0] && tx_dma_en) |=> raw_status[0]);
   // R6: a transmit completion pulse always leaves the bit set
   p_txdone_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_dma_done |=> raw_status[0]);
   // R9: end of transmission follows a drained transmitter
   p_eot_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_free == EMPTY_FREE && shifter_idle) |=> raw_status[2]);
   // R11: the interrupt needs some raw status bit
   p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (raw_status != 3'b000));
endmodule

// File: tb/sim_sp_dma_req.sv
module sim_sp_dma_req;
   localparam time CLK_PER = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_dma_en = 0, rx_dma_en = 0;
   logic [3:0] tx_free = 0, rx_fill = 0;
   logic       tx_dma_done = 0, rx_dma_done = 0, shifter_idle = 0;
   logic       clr_tx_done = 0, clr_rx_done = 0, clr_eot = 0;
   logic [2:0] irq_mask = 0;
   logic       tx_sreq, tx_breq, rx_sreq, rx_breq, irq;
   logic [2:0] raw_status;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #(CLK_PER/2) clk = ~clk;

   sp_dma_req u0 (
      .clk(clk), .rst_n(rst_n), .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
      .tx_free(tx_free), .rx_fill(rx_fill), .tx_dma_done(tx_dma_done),
      .rx_dma_done(rx_dma_done), .shifter_idle(shifter_idle),
      .clr_tx_done(clr_tx_done), .clr_rx_done(clr_rx_done), .clr_eot(clr_eot),
      .irq_mask(irq_mask), .tx_sreq(tx_sreq), .tx_breq(tx_breq),
      .rx_sreq(rx_sreq), .rx_breq(rx_breq), .raw_status(raw_status), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // one clock: inputs set before the call take effect at the coming edge,
   // pulses are dropped at the following falling edge
   task automatic tick();
      @(negedge clk);
      tx_dma_done = 0; rx_dma_done = 0;
      clr_tx_done = 0; clr_rx_done = 0; clr_eot = 0;
      #1;
   endtask

   task automatic t_reset();
      chk("R12 raw_status after reset", raw_status, 3'b000);
      chk("R12 irq after reset", irq, 0);
   endtask

   task automatic t_rx_levels();
      rx_dma_en = 1;
      foreach (int_vals[i]) begin
         rx_fill = int_vals[i][3:0];
         #1;
         chk($sformatf("R1 rx_sreq fill=%0d", int_vals[i]), rx_sreq, int_vals[i] >= 1);
         chk($sformatf("R2 rx_breq fill=%0d", int_vals[i]), rx_breq, int_vals[i] >= 4);
      end
   endtask

   task automatic t_tx_levels();
      tx_dma_en = 1;
      foreach (int_vals[i]) begin
         tx_free = int_vals[i][3:0];
         #1;
         chk($sformatf("R3 tx_sreq free=%0d", int_vals[i]), tx_sreq, int_vals[i] >= 1);
         chk($sformatf("R4 tx_breq free=%0d", int_vals[i]), tx_breq, int_vals[i] >= 4);
      end
   endtask

   task automatic t_gate();
      rx_fill = 8; tx_free = 7; rx_dma_en = 0; tx_dma_en = 0;
      #1;
      chk("R5 rx requests off", {rx_sreq, rx_breq}, 2'b00);
      chk("R5 tx requests off", {tx_sreq, tx_breq}, 2'b00);
      tx_free = 0; rx_fill = 0;
   endtask

   task automatic t_tx_done();
      @(negedge clk);
      tx_dma_en = 1; tx_dma_done = 1;
      tick();
      chk("R6 tx done set", raw_status[0], 1);
      tick();
      chk("R6 tx done held", raw_status[0], 1);
      clr_tx_done = 1;
      tick();
      chk("R7 clear ignored while enabled", raw_status[0], 1);
      tx_dma_en = 0; clr_tx_done = 1;
      tick();
      chk("R7 clear accepted when disabled", raw_status[0], 0);
   endtask

   task automatic t_rx_done();
      rx_dma_en = 1; rx_dma_done = 1;
      tick();
      chk("R8 rx done set", raw_status[1], 1);
      clr_rx_done = 1;
      tick();
      chk("R8 rx done cleared with enable high", raw_status[1], 0);
      rx_dma_done = 1; clr_rx_done = 1;
      tick();
      chk("R10 set wins over clear", raw_status[1], 1);
      rx_dma_en = 0;
   endtask

   task automatic t_irq();
      irq_mask = 3'b000; #1;
      chk("R11 irq masked", irq, 0);
      irq_mask = 3'b001; #1;
      chk("R11 irq other bit only", irq, 0);
      irq_mask = 3'b010; #1;
      chk("R11 irq rx done unmasked", irq, 1);
      irq_mask = 3'b000;
      clr_rx_done = 1;
      tick();
      chk("R8 rx done cleared", raw_status[1], 0);
   endtask

   task automatic t_eot();
      tick();
      chk("R9 eot clear before drain", raw_status[2], 0);
      tx_free = 8; shifter_idle = 1;
      tick();
      chk("R9 eot set on drain", raw_status[2], 1);
      clr_eot = 1;
      tick();
      chk("R9 eot kept while drained", raw_status[2], 1);
      shifter_idle = 0; clr_eot = 1;
      tick();
      chk("R9 eot cleared", raw_status[2], 0);
      tx_free = 7; shifter_idle = 1;
      tick();
      chk("R9 eot stays clear with a word left", raw_status[2], 0);
      shifter_idle = 0; tx_free = 0;
   endtask

   int int_vals[5] = '{0, 1, 3, 4, 8};

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      t_reset();
      t_rx_levels();
      int_vals = '{0, 1, 3, 4, 7};
      t_tx_levels();
      t_gate();
      t_tx_done();
      t_rx_done();
      t_irq();
      t_eot();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      #(CLK_PER * 20000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule